// File: doc/BRIEF.md
# LED String Open/Short Detector

This block watches the voltage at the bottom of up to four LED strings, each driven by a current sink, and decides whether a string has gone open or has shorted LEDs. Each output voltage arrives as a digitized millivolt sample, with a strobe that marks a valid sample set. Programmed codes set three levels. The headroom level is the sink saturation voltage plus an offset. The regulation window runs from the headroom level up to the headroom level plus a hysteresis. The short threshold is a fixed voltage.

The block runs in two modes. In display mode the strings share one adaptive boost loop. A string that sits below the headroom level counts as open only once the boost has reached its maximum. A string above the short threshold counts as shorted only while some other healthy string is inside the regulation window. In cluster mode each string stands alone, so each level comparison is enough on its own.

A detected string is remembered for the rest of the power cycle. That string is taken out of the boost voltage loop in display mode, and its sink and PWM are turned off in both modes. Two summary flags tell software that an open or a short appeared. Software can clear these flags. A flag rises again only when a string that has not faulted before develops a fault.

Top module: `led_string_fault_mon`

## Requirements
- R1: The headroom level equals the saturation voltage plus an offset chosen by the 3-bit headroom code: 7→50, 6→175, 5→300, 4→450, 3→575, 2→700, 1→875, 0→1000 mV. A string counts as below headroom when its sample is strictly less than this level.
- R2: The 2-bit short code selects the short threshold: 0→3600, 1→3600, 2→6900, 3→10600 mV. A string counts as above threshold when its sample is strictly greater than the threshold.
- R3: The 2-bit hysteresis code selects the window width: 0→1000, 1→750, 2→500, 3→250 mV. A sample is inside the window when headroom level ≤ sample ≤ headroom level + width.
- R4: In display mode, a string above threshold is reported as shorted only if at least one string that has not faulted is inside the window in the same sample.
- R5: In display mode, a string below headroom is reported as open only while boost_at_max is 1.
- R6: In cluster mode, being below headroom is enough to report an open, and being above threshold is enough to report a short.
- R7: A sample is evaluated only when sample_vld is 1 and the enable for the active mode is 1 (en_disp_flt in display mode, en_clu_flt in cluster mode). Otherwise no fault bit or flag changes.
- R8: str_fault[i] sets in the cycle after string i is detected. It stays set until rst_n is asserted, and clear_flags does not affect it.
- R9: open_flag and short_flag set in the cycle after a new open or short is detected on a string whose str_fault bit is 0. A clear_flags pulse without a new detection clears both flags. A string that has already faulted never raises a flag again. A new detection in the same cycle as clear_flags wins over the clear.
- R10: drive_off equals str_fault in both modes. loop_excl equals str_fault in display mode and is 0 in cluster mode. Strings that have faulted are not evaluated again and do not count toward the window condition.
- R11: While rst_n is low and after it is released, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sample_vld | input | 1 | Marks a valid set of output samples |
| out_mv | input | NUM_STR*MV_W | Per-string voltage samples in mV; string i at [i*MV_W +: MV_W] |
| vsat_mv | input | MV_W | Sink saturation voltage in mV |
| hdr_code | input | 3 | Headroom offset code |
| hyst_code | input | 2 | Window width code |
| short_code | input | 2 | Short threshold code |
| boost_at_max | input | 1 | Adaptive boost has reached its ceiling |
| cluster_mode | input | 1 | 1 = cluster mode, 0 = display mode |
| en_disp_flt | input | 1 | Enables detection in display mode |
| en_clu_flt | input | 1 | Enables detection in cluster mode |
| clear_flags | input | 1 | Clears the summary flags |
| str_fault | output | NUM_STR | Per-string fault record |
| open_flag | output | 1 | A new open string was reported |
| short_flag | output | 1 | A new shorted string was reported |
| loop_excl | output | NUM_STR | Remove the string from the boost voltage loop |
| drive_off | output | NUM_STR | Disable the string's sink and PWM |

## Verification
The table-driven part sends single sample sets from reset. These separate a short with a window partner from a short without one, and an open with boost at maximum from an open without it, in each mode. They also place samples exactly on each threshold, one millivolt past it, and on both edges of the window, under several codes. The directed part steps through a longer history: a clear followed by the same fault on the same string, which must stay silent, and then a fault on a new string, which must raise the flag. It also checks a faulted string sitting inside the window, which must not enable a short, a clear that arrives together with a new fault, and the effect of the enables and the mode on the exclusion outputs.

// File: rtl/led_flt_pkg.sv
package led_flt_pkg;

  // offset above saturation for the headroom level, in mV
  function automatic logic [10:0] hdr_offset_mv(input logic [2:0] code);
    case (code)
      3'd7:    hdr_offset_mv = 11'd50;
      3'd6:    hdr_offset_mv = 11'd175;
      3'd5:    hdr_offset_mv = 11'd300;
      3'd4:    hdr_offset_mv = 11'd450;
      3'd3:    hdr_offset_mv = 11'd575;
      3'd2:    hdr_offset_mv = 11'd700;
      3'd1:    hdr_offset_mv = 11'd875;
      default: hdr_offset_mv = 11'd1000;
    endcase
  endfunction

  // window width above the headroom level, in mV
  function automatic logic [10:0] win_width_mv(input logic [1:0] code);
    case (code)
      2'd0:    win_width_mv = 11'd1000;
      2'd1:    win_width_mv = 11'd750;
      2'd2:    win_width_mv = 11'd500;
      default: win_width_mv = 11'd250;
    endcase
  endfunction

  // short detection threshold, in mV
  function automatic logic [13:0] short_thr_mv(input logic [1:0] code);
    case (code)
      2'd2:    short_thr_mv = 14'd6900;
      2'd3:    short_thr_mv = 14'd10600;
      default: short_thr_mv = 14'd3600;
    endcase
  endfunction

endpackage

// File: rtl/led_lvl_decode.sv
module led_lvl_decode
  import led_flt_pkg::*;
#(
  parameter int MV_W  = 14,
  parameter int LVL_W = MV_W + 2
) (
  input  logic [MV_W-1:0]  vsat_mv,
  input  logic [2:0]       hdr_code,
  input  logic [1:0]       hyst_code,
  input  logic [1:0]       short_code,
  output logic [LVL_W-1:0] hdr_lvl,
  output logic [LVL_W-1:0] win_hi,
  output logic [LVL_W-1:0] short_lvl
);

  logic [LVL_W-1:0] off_ext;
  logic [LVL_W-1:0] wid_ext;

  always_comb begin
    off_ext   = LVL_W'(hdr_offset_mv(hdr_code));
    wid_ext   = LVL_W'(win_width_mv(hyst_code));
    hdr_lvl   = LVL_W'(vsat_mv) + off_ext;
    win_hi    = hdr_lvl + wid_ext;
    short_lvl = LVL_W'(short_thr_mv(short_code));
  end

  // R3
  always_comb begin
    win_order_chk: assert (win_hi > hdr_lvl)
      else $error("window top not above headroom level");
  end

endmodule

// File: rtl/led_str_cmp.sv
module led_str_cmp #(
  parameter int MV_W  = 14,
  parameter int LVL_W = MV_W + 2
) (
  input  logic [MV_W-1:0]  v_mv,
  input  logic [LVL_W-1:0] hdr_lvl,
  input  logic [LVL_W-1:0] win_hi,
  input  logic [LVL_W-1:0] short_lvl,
  output logic             below_hdr,
  output logic             in_win,
  output logic             above_thr
);

  logic [LVL_W-1:0] v_ext;

  always_comb begin
    v_ext     = LVL_W'(v_mv);
    below_hdr = v_ext < hdr_lvl;
    in_win    = (v_ext >= hdr_lvl) && (v_ext <= win_hi);
    above_thr = v_ext > short_lvl;
  end

endmodule

// File: rtl/led_fault_rec.sv
module led_fault_rec #(
  parameter int NUM_STR = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_vld,
  input  logic               det_en,
  input  logic               cluster_mode,
  input  logic               boost_at_max,
  input  logic               clear_flags,
  input  logic [NUM_STR-1:0] below_hdr,
  input  logic [NUM_STR-1:0] in_win,
  input  logic [NUM_STR-1:0] above_thr,
  output logic [NUM_STR-1:0] str_fault,
  output logic               open_flag,
  output logic               short_flag
);

  logic [NUM_STR-1:0] healthy;
  logic [NUM_STR-1:0] new_open;
  logic [NUM_STR-1:0] new_short;
  logic               partner_ok;
  logic               open_gate;
  logic               eval_en;
  logic               upd_en;
  logic [NUM_STR-1:0] fault_d;
  logic               open_d;
  logic               short_d;

  // next-state logic
  always_comb begin
    healthy    = ~str_fault;
    eval_en    = sample_vld && det_en;
    partner_ok = cluster_mode || (|(in_win & healthy));
    open_gate  = cluster_mode || boost_at_max;
    new_open   = below_hdr & healthy & {NUM_STR{open_gate && eval_en}};
    new_short  = above_thr & healthy & {NUM_STR{partner_ok && eval_en}};
    fault_d    = str_fault | new_open | new_short;
    open_d     = (open_flag && !clear_flags) || (|new_open);
    short_d    = (short_flag && !clear_flags) || (|new_short);
    upd_en     = eval_en || clear_flags;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      str_fault  <= '0;
      open_flag  <= 1'b0;
      short_flag <= 1'b0;
    end else if (upd_en) begin
      str_fault  <= fault_d;
      open_flag  <= open_d;
      short_flag <= short_d;
    end
  end

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (str_fault & $past(str_fault)) == $past(str_fault));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_vld && det_en) |=> $stable(str_fault));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_flags && !sample_vld) |=> (!open_flag && !short_flag));

  // R9
  short_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_flag) |-> ($countones(str_fault) > $countones($past(str_fault))));

  // R5
  open_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !cluster_mode && !boost_at_max && !clear_flags)
      |=> (open_flag == $past(open_flag)));

endmodule

// File: rtl/led_string_fault_mon.sv
module led_string_fault_mon #(
  parameter int NUM_STR = 4,
  parameter int MV_W    = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_vld,
  input  logic [NUM_STR*MV_W-1:0] out_mv,
  input  logic [MV_W-1:0]         vsat_mv,
  input  logic [2:0]              hdr_code,
  input  logic [1:0]              hyst_code,
  input  logic [1:0]              short_code,
  input  logic                    boost_at_max,
  input  logic                    cluster_mode,
  input  logic                    en_disp_flt,
  input  logic                    en_clu_flt,
  input  logic                    clear_flags,
  output logic [NUM_STR-1:0]      str_fault,
  output logic                    open_flag,
  output logic                    short_flag,
  output logic [NUM_STR-1:0]      loop_excl,
  output logic [NUM_STR-1:0]      drive_off
);

  localparam int LVL_W = MV_W + 2;

  logic [LVL_W-1:0]   hdr_lvl;
  logic [LVL_W-1:0]   win_hi;
  logic [LVL_W-1:0]   short_lvl;
  logic [NUM_STR-1:0] below_hdr;
  logic [NUM_STR-1:0] in_win;
  logic [NUM_STR-1:0] above_thr;
  logic               det_en;

  led_lvl_decode #(.MV_W(MV_W), .LVL_W(LVL_W)) u_lvl (
    .vsat_mv   (vsat_mv),
    .hdr_code  (hdr_code),
    .hyst_code (hyst_code),
    .short_code(short_code),
    .hdr_lvl   (hdr_lvl),
    .win_hi    (win_hi),
    .short_lvl (short_lvl)
  );

  for (genvar gi = 0; gi < NUM_STR; gi++) begin : g_str
    led_str_cmp #(.MV_W(MV_W), .LVL_W(LVL_W)) u_cmp (
      .v_mv     (out_mv[gi*MV_W +: MV_W]),
      .hdr_lvl  (hdr_lvl),
      .win_hi   (win_hi),
      .short_lvl(short_lvl),
      .below_hdr(below_hdr[gi]),
      .in_win   (in_win[gi]),
      .above_thr(above_thr[gi])
    );
  end

  always_comb begin
    det_en = cluster_mode ? en_clu_flt : en_disp_flt;
  end

  led_fault_rec #(.NUM_STR(NUM_STR)) u_rec (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_vld  (sample_vld),
    .det_en      (det_en),
    .cluster_mode(cluster_mode),
    .boost_at_max(boost_at_max),
    .clear_flags (clear_flags),
    .below_hdr   (below_hdr),
    .in_win      (in_win),
    .above_thr   (above_thr),
    .str_fault   (str_fault),
    .open_flag   (open_flag),
    .short_flag  (short_flag)
  );

  always_comb begin
    drive_off = str_fault;
    loop_excl = str_fault & {NUM_STR{!cluster_mode}};
  end

  // R10
  excl_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_excl & ~drive_off) == '0);

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (str_fault == '0 && !open_flag && !short_flag));

endmodule

// File: tb/led_string_fault_mon_tb.sv
module led_string_fault_mon_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int MW = 14;

  typedef struct packed {
    logic [13:0] v0, v1, v2, v3;
    logic        cl, bm;
    logic [2:0]  hc;
    logic [1:0]  yc, sc;
    logic [3:0]  ef;
    logic        eo, es;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    // R4: all in window, no short
    '{14'd900, 14'd900, 14'd900, 14'd900, 1'b0, 1'b0, 3'd4, 2'd2, 2'd2, 4'b0000, 1'b0, 1'b0, 4'd4},
    // R4: short with window partner
    '{14'd7000, 14'd900, 14'd900, 14'd900, 1'b0, 1'b0, 3'd4, 2'd2, 2'd2, 4'b0001, 1'b0, 1'b1, 4'd4},
    // R4: short without window partner
    '{14'd7000, 14'd2000, 14'd2000, 14'd2000, 1'b0, 1'b0, 3'd4, 2'd2, 2'd2, 4'b0000, 1'b0, 1'b0, 4'd4},
    // R5: low string, boost not at max
    '{14'd900, 14'd900, 14'd300, 14'd900, 1'b0, 1'b0, 3'd4, 2'd2, 2'd2, 4'b0000, 1'b0, 1'b0, 4'd5},
    // R5: low string, boost at max
    '{14'd900, 14'd900, 14'd300, 14'd900, 1'b0, 1'b1, 3'd4, 2'd2, 2'd2, 4'b0100, 1'b1, 1'b0, 4'd5},
    // R6: cluster open without boost max
    '{14'd2000, 14'd300, 14'd2000, 14'd2000, 1'b1, 1'b0, 3'd4, 2'd2, 2'd2, 4'b0010, 1'b1, 1'b0, 4'd6},
    // R6: cluster short without partner
    '{14'd2000, 14'd2000, 14'd2000, 14'd7000, 1'b1, 1'b0, 3'd4, 2'd2, 2'd2, 4'b1000, 1'b0, 1'b1, 4'd6},
    // R2: 10600 threshold
    '{14'd7000, 14'd900, 14'd900, 14'd900, 1'b0, 1'b0, 3'd4, 2'd2, 2'd3, 4'b0000, 1'b0, 1'b0, 4'd2},
    // R2: code 1 = 3600
    '{14'd4000, 14'd900, 14'd900, 14'd900, 1'b0, 1'b0, 3'd4, 2'd2, 2'd1, 4'b0001, 1'b0, 1'b1, 4'd2},
    // R2: code 0 = 3600
    '{14'd4000, 14'd900, 14'd900, 14'd900, 1'b0, 1'b0, 3'd4, 2'd2, 2'd0, 4'b0001, 1'b0, 1'b1, 4'd2},
    // R2: exactly at 6900
    '{14'd6900, 14'd900, 14'd900, 14'd900, 1'b0, 1'b0, 3'd4, 2'd2, 2'd2, 4'b0000, 1'b0, 1'b0, 4'd2},
    // R2: 1 mV above 6900
    '{14'd6901, 14'd900, 14'd900, 14'd900, 1'b0, 1'b0, 3'd4, 2'd2, 2'd2, 4'b0001, 1'b0, 1'b1, 4'd2},
    // R3: partner at window top 1150
    '{14'd7000, 14'd1150, 14'd2000, 14'd2000, 1'b0, 1'b0, 3'd4, 2'd2, 2'd2, 4'b0001, 1'b0, 1'b1, 4'd3},
    // R3: partner 1 mV above window
    '{14'd7000, 14'd1151, 14'd2000, 14'd2000, 1'b0, 1'b0, 3'd4, 2'd2, 2'd2, 4'b0000, 1'b0, 1'b0, 4'd3},
    // R3: code 0 = 1000 width, partner at 1600
    '{14'd7000, 14'd1600, 14'd2000, 14'd2000, 1'b0, 1'b0, 3'd4, 2'd0, 2'd2, 4'b0001, 1'b0, 1'b1, 4'd3},
    // R3: code 3 = 250 width, partner at 1000
    '{14'd7000, 14'd1000, 14'd2000, 14'd2000, 1'b0, 1'b0, 3'd4, 2'd3, 2'd2, 4'b0000, 1'b0, 1'b0, 4'd3},
    // R5: exactly at headroom
    '{14'd900, 14'd900, 14'd650, 14'd900, 1'b0, 1'b1, 3'd4, 2'd2, 2'd2, 4'b0000, 1'b0, 1'b0, 4'd5},
    // R5: 1 mV below headroom
    '{14'd900, 14'd900, 14'd649, 14'd900, 1'b0, 1'b1, 3'd4, 2'd2, 2'd2, 4'b0100, 1'b1, 1'b0, 4'd5},
    // R1: code 7 level 250, sample 249
    '{14'd2000, 14'd249, 14'd2000, 14'd2000, 1'b1, 1'b0, 3'd7, 2'd2, 2'd2, 4'b0010, 1'b1, 1'b0, 4'd1},
    // R1: code 7 level 250, sample 250
    '{14'd2000, 14'd250, 14'd2000, 14'd2000, 1'b1, 1'b0, 3'd7, 2'd2, 2'd2, 4'b0000, 1'b0, 1'b0, 4'd1},
    // R1: code 0 level 1200, sample 1199
    '{14'd2000, 14'd1199, 14'd2000, 14'd2000, 1'b1, 1'b0, 3'd0, 2'd2, 2'd2, 4'b0010, 1'b1, 1'b0, 4'd1},
    // R1: code 0 level 1200, sample 1200
    '{14'd2000, 14'd1200, 14'd2000, 14'd2000, 1'b1, 1'b0, 3'd0, 2'd2, 2'd2, 4'b0000, 1'b0, 1'b0, 4'd1}
  };

  logic              clk;
  logic              rst_n;
  logic              sample_vld;
  logic [NS*MW-1:0]  out_mv;
  logic [MW-1:0]     vsat_mv;
  logic [2:0]        hdr_code;
  logic [1:0]        hyst_code;
  logic [1:0]        short_code;
  logic              boost_at_max;
  logic              cluster_mode;
  logic              en_disp_flt;
  logic              en_clu_flt;
  logic              clear_flags;
  logic [NS-1:0]     str_fault;
  logic              open_flag;
  logic              short_flag;
  logic [NS-1:0]     loop_excl;
  logic [NS-1:0]     drive_off;

  int n_chk;
  int n_err;

  led_string_fault_mon #(.NUM_STR(NS), .MV_W(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .out_mv(out_mv),
    .vsat_mv(vsat_mv), .hdr_code(hdr_code), .hyst_code(hyst_code),
    .short_code(short_code), .boost_at_max(boost_at_max),
    .cluster_mode(cluster_mode), .en_disp_flt(en_disp_flt),
    .en_clu_flt(en_clu_flt), .clear_flags(clear_flags),
    .str_fault(str_fault), .open_flag(open_flag), .short_flag(short_flag),
    .loop_excl(loop_excl), .drive_off(drive_off)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sample_vld = 1'b0;
    clear_flags = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // inputs change at a falling edge, captured at the next rising edge,
  // checked at the falling edge after that
  task automatic pulse(input logic clr);
    sample_vld = 1'b1;
    clear_flags = clr;
    @(negedge clk);
    sample_vld = 1'b0;
    clear_flags = 1'b0;
  endtask

  task automatic set_v(input int a, input int b, input int c, input int d);
    out_mv = {MW'(d), MW'(c), MW'(b), MW'(a)};
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
      end
    end
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    rst_n = 1'b0;
    sample_vld = 1'b0;
    clear_flags = 1'b0;
    out_mv = '0;
    vsat_mv = MW'(200);
    hdr_code = 3'd4;
    hyst_code = 2'd2;
    short_code = 2'd2;
    boost_at_max = 1'b0;
    cluster_mode = 1'b0;
    en_disp_flt = 1'b1;
    en_clu_flt = 1'b1;

    // R11: outputs during reset
    repeat (2) @(negedge clk);
    check("R11 fault in reset", 32'(str_fault), 32'h0);
    check("R11 flags in reset", 32'({open_flag, short_flag}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 drive_off after reset", 32'(drive_off), 32'h0);
    check("R11 loop_excl after reset", 32'(loop_excl), 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      do_reset();
      set_v(TBL[i].v0, TBL[i].v1, TBL[i].v2, TBL[i].v3);
      cluster_mode = TBL[i].cl;
      boost_at_max = TBL[i].bm;
      hdr_code = TBL[i].hc;
      hyst_code = TBL[i].yc;
      short_code = TBL[i].sc;
      pulse(1'b0);
      check($sformatf("R%0d row %0d str_fault", TBL[i].rq, i), 32'(str_fault), 32'(TBL[i].ef));
      check($sformatf("R%0d row %0d open_flag", TBL[i].rq, i), 32'(open_flag), 32'(TBL[i].eo));
      check($sformatf("R%0d row %0d short_flag", TBL[i].rq, i), 32'(short_flag), 32'(TBL[i].es));
    end
    hdr_code = 3'd4;
    hyst_code = 2'd2;
    short_code = 2'd2;

    // R7: display enable off blocks a valid short
    do_reset();
    cluster_mode = 1'b0; boost_at_max = 1'b0;
    en_disp_flt = 1'b0; en_clu_flt = 1'b1;
    set_v(7000, 900, 900, 900);
    pulse(1'b0);
    check("R7 display enable off", 32'({str_fault, short_flag}), 32'h0);
    // R7: cluster enable off blocks an open
    en_disp_flt = 1'b1; en_clu_flt = 1'b0; cluster_mode = 1'b1;
    set_v(2000, 300, 2000, 2000);
    pulse(1'b0);
    check("R7 cluster enable off", 32'({str_fault, open_flag}), 32'h0);
    // R7: no strobe, no evaluation
    en_clu_flt = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 no sample_vld", 32'({str_fault, open_flag}), 32'h0);

    // R8 / R9: clear, same-string retrigger blocked, new string reported
    do_reset();
    cluster_mode = 1'b0;
    set_v(7000, 900, 900, 900);
    pulse(1'b0);
    check("R9 first short flag", 32'(short_flag), 32'h1);
    pulse(1'b1);
    check("R9 flag cleared", 32'(short_flag), 32'h0);
    check("R8 fault kept after clear", 32'(str_fault), 32'h1);
    set_v(7000, 900, 900, 900);
    pulse(1'b0);
    check("R9 same string no retrigger", 32'(short_flag), 32'h0);
    set_v(7000, 900, 900, 7000);
    pulse(1'b0);
    check("R9 new string flag", 32'(short_flag), 32'h1);
    check("R8 fault bits accumulate", 32'(str_fault), 32'h9);

    // R10: exclusion outputs by mode
    check("R10 loop_excl display", 32'(loop_excl), 32'h9);
    check("R10 drive_off display", 32'(drive_off), 32'h9);
    cluster_mode = 1'b1;
    #1;
    check("R10 loop_excl cluster", 32'(loop_excl), 32'h0);
    check("R10 drive_off cluster", 32'(drive_off), 32'h9);
    cluster_mode = 1'b0;

    // R10: faulted string in window does not enable a short
    do_reset();
    boost_at_max = 1'b1;
    set_v(900, 900, 300, 900);
    pulse(1'b0);
    check("R10 open recorded", 32'(str_fault), 32'h4);
    boost_at_max = 1'b0;
    set_v(7000, 2000, 900, 2000);
    pulse(1'b0);
    check("R10 faulted partner ignored", 32'({str_fault, short_flag}), 32'({4'h4, 1'b0}));

    // R9: new detection wins over a simultaneous clear
    do_reset();
    set_v(7000, 900, 900, 900);
    pulse(1'b0);
    set_v(7000, 900, 900, 7000);
    pulse(1'b1);
    check("R9 detect beats clear", 32'({str_fault, short_flag}), 32'({4'h9, 1'b1}));
    check("R9 open flag untouched", 32'(open_flag), 32'h0);

    // R11: reset clears the record
    do_reset();
    check("R11 record cleared by reset", 32'(str_fault), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule